// File: doc/BRIEF.md
# Multi-Output Programmable Video Timing Generator

This block produces the raster timing for a display pipeline. A pixel counter and a line counter sweep a frame whose size comes from two programmed values: the number of clock cycles per line, and the field length given in half-lines. From that position the block derives a display-enable window and four independent sync pairs. Each pair has a horizontal pulse whose edges may wrap past the end of the line. Each also has a vertical pulse whose edges are set by a line number and by a pixel offset within that line. Separate top-field and bottom-field copies exist for the vertical settings and for the window.

Software programs the block through a 32-bit register bus. A write to the restart register starts the raster at pixel 0 of line 1. All timing values are held in shadow copies, which are loaded only at a frame boundary or on a restart. Reaching the first pixel of a field sets a sticky status bit, one bit for each field kind. An interrupt line reports the status bits that are enabled in the mask. The status is cleared one bit at a time, and the mask is set and cleared one bit at a time.

Top module: `vtg_timing_gen`

## Requirements
- R1: The pixel counter counts 0 to L-1 (L = line length register at 0x08) and wraps. The line counter counts 1 to floor(H/2) (H = half-line register at 0x0C), so a field lasts L*floor(H/2) cycles.
- R2: Writing a word with bit 0 set to 0x10 loads the shadow configuration. The raster restarts at pixel 0 of line 1 of a top field, and every vsync output is driven low.
- R3: Lane i has its registers at base 0xC0 + 0x20*i. Its hsync word at base+0x0 holds the start pixel in bits 15:0 and the stop pixel in bits 31:16. Hsync is high when the pixel count lies in the inclusive range from start to stop. When stop is less than start, the range wraps across the end of the line.
- R4: The vsync line word holds the rising line in bits 15:0 and the falling line in bits 31:16: top copy at base+0x4, bottom copy at base+0x8. The vsync offset word holds the rising pixel in bits 15:0 and the falling pixel in bits 31:16: top copy at base+0xC, bottom copy at base+0x10. Vsync goes high at the rising point and low at the falling point. If both points coincide, rising wins. Between the two points it holds its value, including across frame boundaries.
- R5: Display enable is high when both the line and the pixel lie inclusively inside the window. A window word holds the line in bits 31:16 and the pixel in bits 15:0. The top field uses start 0x40 and stop 0x44; the bottom field uses start 0x48 and stop 0x4C.
- R6: Hsync, vsync and display enable are registered. Each shows the decision for a raster position one clock after the counters hold that position.
- R7: While the counters sit at pixel 0 of line 1 of a top field, status bit 1 (read at 0x78) is set. At the same point of a bottom field, status bit 0 is set. The bit is readable from the next cycle and stays set until it is cleared.
- R8: Writing to 0x7C clears each status bit written as 1 and leaves bits written as 0 alone. A field event in the same cycle as the clear keeps its bit set.
- R9: Writing to 0x8C sets the mask bits written as 1, and writing to 0x88 clears them. Other mask bits keep their value. The mask reads back at 0x8C. The interrupt output is high while any status bit and its mask bit are both 1.
- R10: Timing register writes take effect at the next frame boundary or at a restart. The frame that is running is unaffected.
- R11: With an odd H, fields alternate top, bottom, top, and so on, starting with a top field. A bottom field uses the bottom vsync and window copies and raises status bit 0. With an even H, every field is a top field.
- R12: After reset all sync and enable outputs and the interrupt are low, and the mask is 0. The line length reads 16 and the half-line count reads 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (12) | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| hsync_o | output | NUM_SYNC (4) | Horizontal sync, one per lane |
| vsync_o | output | NUM_SYNC (4) | Vertical sync, one per lane |
| de_o | output | 1 | Display enable for the active window |
| irq_o | output | 1 | Interrupt, status AND mask |

## Verification
The hardest condition to reach from the ports is a status clear that lands in the very cycle a field event fires. To get there, the bench keeps a cycle count that starts at the restart edge and issues the clear write while the counters sit at the origin of a later frame. Bottom-field behaviour appears only with an odd half-line count, so a second configuration alternates fields. That configuration lets the bench sweep every position of four fields, with vertical edges that carry over field and frame boundaries. A third case writes an hsync word in the middle of a frame and follows the output across the next boundary to show that the change is deferred.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int unsigned VTG_CW = 16;

  localparam int unsigned VTG_A_MODE      = 'h000;
  localparam int unsigned VTG_A_LEN       = 'h008;
  localparam int unsigned VTG_A_HALF      = 'h00C;
  localparam int unsigned VTG_A_RESTART   = 'h010;
  localparam int unsigned VTG_A_WIN_TS    = 'h040;
  localparam int unsigned VTG_A_WIN_TE    = 'h044;
  localparam int unsigned VTG_A_WIN_BS    = 'h048;
  localparam int unsigned VTG_A_WIN_BE    = 'h04C;
  localparam int unsigned VTG_A_STAT      = 'h078;
  localparam int unsigned VTG_A_STAT_CLR  = 'h07C;
  localparam int unsigned VTG_A_MASK_CLR  = 'h088;
  localparam int unsigned VTG_A_MASK_SET  = 'h08C;
  localparam int unsigned VTG_A_LANE0     = 'h0C0;
  localparam int unsigned VTG_LANE_STRIDE = 'h020;
  localparam int unsigned VTG_O_HS        = 'h000;
  localparam int unsigned VTG_O_VL_TOP    = 'h004;
  localparam int unsigned VTG_O_VL_BOT    = 'h008;
  localparam int unsigned VTG_O_VO_TOP    = 'h00C;
  localparam int unsigned VTG_O_VO_BOT    = 'h010;

  typedef logic [VTG_CW-1:0] coord_t;

  // hi sits in bits 31:16, lo in bits 15:0
  typedef struct packed {
    coord_t hi;
    coord_t lo;
  } pair_t;

  typedef struct packed {
    pair_t hs;
    pair_t vl_top;
    pair_t vl_bot;
    pair_t vo_top;
    pair_t vo_bot;
  } lane_cfg_t;

  typedef struct packed {
    pair_t top_start;
    pair_t top_stop;
    pair_t bot_start;
    pair_t bot_stop;
  } win_cfg_t;

  function automatic logic in_span(input coord_t pos, input coord_t first, input coord_t last);
    if (first <= last) return (pos >= first) && (pos <= last);
    else               return (pos >= first) || (pos <= last);
  endfunction

  function automatic logic in_range(input coord_t pos, input coord_t first, input coord_t last);
    return (pos >= first) && (pos <= last);
  endfunction

  function automatic coord_t lines_of(input coord_t half_lines);
    return half_lines >> 1;
  endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned NUM_SYNC = 4,
  parameter int unsigned AW       = 12,
  parameter int unsigned DEF_LINE = 16,
  parameter int unsigned DEF_HALF = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            frame_wrap_i,
  input  logic [1:0]      status_i,
  input  logic [1:0]      mask_i,
  output coord_t          len_o,
  output coord_t          half_o,
  output win_cfg_t        win_o,
  output lane_cfg_t       lane_o [NUM_SYNC],
  output logic            restart_o,
  output logic [1:0]      stat_clr_o,
  output logic [1:0]      mask_set_o,
  output logic [1:0]      mask_clr_o
);

  localparam coord_t LEN_RST  = coord_t'(DEF_LINE);
  localparam coord_t HALF_RST = coord_t'(DEF_HALF);

  logic [31:0] mode_q;
  coord_t      len_q, half_q;
  win_cfg_t    win_q;
  lane_cfg_t   lane_q [NUM_SYNC];

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned off);
    return a == AW'(off);
  endfunction

  function automatic int unsigned lane_addr(input int unsigned lane, input int unsigned off);
    return VTG_A_LANE0 + lane * VTG_LANE_STRIDE + off;
  endfunction

  assign restart_o  = bus_wr && hit(bus_addr, VTG_A_RESTART) && bus_wdata[0];
  assign stat_clr_o = (bus_wr && hit(bus_addr, VTG_A_STAT_CLR)) ? bus_wdata[1:0] : 2'b00;
  assign mask_set_o = (bus_wr && hit(bus_addr, VTG_A_MASK_SET)) ? bus_wdata[1:0] : 2'b00;
  assign mask_clr_o = (bus_wr && hit(bus_addr, VTG_A_MASK_CLR)) ? bus_wdata[1:0] : 2'b00;

  // programmed copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= LEN_RST;
      half_q <= HALF_RST;
      win_q  <= '0;
      for (int i = 0; i < NUM_SYNC; i++) lane_q[i] <= '0;
    end else if (bus_wr) begin
      if (hit(bus_addr, VTG_A_MODE))   mode_q          <= bus_wdata;
      if (hit(bus_addr, VTG_A_LEN))    len_q           <= bus_wdata[VTG_CW-1:0];
      if (hit(bus_addr, VTG_A_HALF))   half_q          <= bus_wdata[VTG_CW-1:0];
      if (hit(bus_addr, VTG_A_WIN_TS)) win_q.top_start <= bus_wdata;
      if (hit(bus_addr, VTG_A_WIN_TE)) win_q.top_stop  <= bus_wdata;
      if (hit(bus_addr, VTG_A_WIN_BS)) win_q.bot_start <= bus_wdata;
      if (hit(bus_addr, VTG_A_WIN_BE)) win_q.bot_stop  <= bus_wdata;
      for (int i = 0; i < NUM_SYNC; i++) begin
        if (hit(bus_addr, lane_addr(i, VTG_O_HS)))     lane_q[i].hs     <= bus_wdata;
        if (hit(bus_addr, lane_addr(i, VTG_O_VL_TOP))) lane_q[i].vl_top <= bus_wdata;
        if (hit(bus_addr, lane_addr(i, VTG_O_VL_BOT))) lane_q[i].vl_bot <= bus_wdata;
        if (hit(bus_addr, lane_addr(i, VTG_O_VO_TOP))) lane_q[i].vo_top <= bus_wdata;
        if (hit(bus_addr, lane_addr(i, VTG_O_VO_BOT))) lane_q[i].vo_bot <= bus_wdata;
      end
    end
  end

  // shadow copies used by the raster, loaded at a boundary or restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_o  <= LEN_RST;
      half_o <= HALF_RST;
      win_o  <= '0;
      for (int i = 0; i < NUM_SYNC; i++) lane_o[i] <= '0;
    end else if (frame_wrap_i || restart_o) begin
      len_o  <= len_q;
      half_o <= half_q;
      win_o  <= win_q;
      for (int i = 0; i < NUM_SYNC; i++) lane_o[i] <= lane_q[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, VTG_A_MODE))          bus_rdata = mode_q;
    else if (hit(bus_addr, VTG_A_LEN))      bus_rdata = {16'h0, len_q};
    else if (hit(bus_addr, VTG_A_HALF))     bus_rdata = {16'h0, half_q};
    else if (hit(bus_addr, VTG_A_WIN_TS))   bus_rdata = win_q.top_start;
    else if (hit(bus_addr, VTG_A_WIN_TE))   bus_rdata = win_q.top_stop;
    else if (hit(bus_addr, VTG_A_WIN_BS))   bus_rdata = win_q.bot_start;
    else if (hit(bus_addr, VTG_A_WIN_BE))   bus_rdata = win_q.bot_stop;
    else if (hit(bus_addr, VTG_A_STAT))     bus_rdata = {30'h0, status_i};
    else if (hit(bus_addr, VTG_A_MASK_SET)) bus_rdata = {30'h0, mask_i};
    else if (hit(bus_addr, VTG_A_MASK_CLR)) bus_rdata = {30'h0, mask_i};
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (hit(bus_addr, lane_addr(i, VTG_O_HS)))     bus_rdata = lane_q[i].hs;
      if (hit(bus_addr, lane_addr(i, VTG_O_VL_TOP))) bus_rdata = lane_q[i].vl_top;
      if (hit(bus_addr, lane_addr(i, VTG_O_VL_BOT))) bus_rdata = lane_q[i].vl_bot;
      if (hit(bus_addr, lane_addr(i, VTG_O_VO_TOP))) bus_rdata = lane_q[i].vo_top;
      if (hit(bus_addr, lane_addr(i, VTG_O_VO_BOT))) bus_rdata = lane_q[i].vo_bot;
    end
  end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
  import vtg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart_i,
  input  coord_t len_i,
  input  coord_t half_i,
  output coord_t px_o,
  output coord_t ln_o,
  output logic   bottom_o,
  output logic   wrap_o,
  output logic   origin_o
);

  logic px_last, ln_last;

  assign px_last  = ({1'b0, px_o} + (VTG_CW+1)'(1)) >= {1'b0, len_i};
  assign ln_last  = ln_o >= lines_of(half_i);
  assign wrap_o   = px_last && ln_last;
  assign origin_o = (px_o == '0) && (ln_o == coord_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_o     <= '0;
      ln_o     <= coord_t'(1);
      bottom_o <= 1'b0;
    end else if (restart_i) begin
      px_o     <= '0;
      ln_o     <= coord_t'(1);
      bottom_o <= 1'b0;
    end else if (px_last) begin
      px_o <= '0;
      if (ln_last) begin
        ln_o     <= coord_t'(1);
        bottom_o <= half_i[0] ? ~bottom_o : 1'b0;
      end else begin
        ln_o <= ln_o + coord_t'(1);
      end
    end else begin
      px_o <= px_o + coord_t'(1);
    end
  end

endmodule

// File: rtl/vtg_lane.sv
module vtg_lane
  import vtg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart_i,
  input  coord_t    px_i,
  input  coord_t    ln_i,
  input  logic      bottom_i,
  input  lane_cfg_t cfg_i,
  output logic      hs_o,
  output logic      vs_o
);

  pair_t vl, vo;
  logic  rise_hit, fall_hit;

  assign vl       = bottom_i ? cfg_i.vl_bot : cfg_i.vl_top;
  assign vo       = bottom_i ? cfg_i.vo_bot : cfg_i.vo_top;
  assign rise_hit = (ln_i == vl.lo) && (px_i == vo.lo);
  assign fall_hit = (ln_i == vl.hi) && (px_i == vo.hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      vs_o <= 1'b0;
    end else if (restart_i) begin
      hs_o <= 1'b0;
      vs_o <= 1'b0;
    end else begin
      hs_o <= in_span(px_i, cfg_i.hs.lo, cfg_i.hs.hi);
      if (rise_hit)      vs_o <= 1'b1;
      else if (fall_hit) vs_o <= 1'b0;
    end
  end

endmodule

// File: rtl/vtg_irq.sv
module vtg_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] event_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] set_mask_i,
  input  logic [1:0] clr_mask_i,
  output logic [1:0] status_o,
  output logic [1:0] mask_o,
  output logic       irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= 2'b00;
      mask_o   <= 2'b00;
    end else begin
      status_o <= (status_o & ~clr_i) | event_i;
      mask_o   <= (mask_o & ~clr_mask_i) | set_mask_i;
    end
  end

  assign irq_o = |(status_o & mask_o);

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned NUM_SYNC = 4,
  parameter int unsigned AW       = 12,
  parameter int unsigned DEF_LINE = 16,
  parameter int unsigned DEF_HALF = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_SYNC-1:0] hsync_o,
  output logic [NUM_SYNC-1:0] vsync_o,
  output logic                de_o,
  output logic                irq_o
);

  coord_t    len_a, half_a, px_w, ln_w;
  win_cfg_t  win_a;
  lane_cfg_t lane_a [NUM_SYNC];
  logic      restart_w, wrap_w, origin_w, bottom_w;
  logic      ev_top_w, ev_bot_w;
  logic [1:0] status_w, mask_w, stat_clr_w, mask_set_w, mask_clr_w;
  pair_t     win_start, win_stop;

  vtg_regs #(
    .NUM_SYNC(NUM_SYNC), .AW(AW), .DEF_LINE(DEF_LINE), .DEF_HALF(DEF_HALF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_wrap_i(wrap_w), .status_i(status_w), .mask_i(mask_w),
    .len_o(len_a), .half_o(half_a), .win_o(win_a), .lane_o(lane_a),
    .restart_o(restart_w), .stat_clr_o(stat_clr_w),
    .mask_set_o(mask_set_w), .mask_clr_o(mask_clr_w)
  );

  vtg_raster u_raster (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_w),
    .len_i(len_a), .half_i(half_a),
    .px_o(px_w), .ln_o(ln_w), .bottom_o(bottom_w),
    .wrap_o(wrap_w), .origin_o(origin_w)
  );

  generate
    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_lane
      vtg_lane u_lane (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_w),
        .px_i(px_w), .ln_i(ln_w), .bottom_i(bottom_w), .cfg_i(lane_a[g]),
        .hs_o(hsync_o[g]), .vs_o(vsync_o[g])
      );
    end
  endgenerate

  assign ev_top_w  = origin_w && !bottom_w;
  assign ev_bot_w  = origin_w && bottom_w;

  vtg_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .event_i({ev_top_w, ev_bot_w}), .clr_i(stat_clr_w),
    .set_mask_i(mask_set_w), .clr_mask_i(mask_clr_w),
    .status_o(status_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  assign win_start = bottom_w ? win_a.bot_start : win_a.top_start;
  assign win_stop  = bottom_w ? win_a.bot_stop  : win_a.top_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         de_o <= 1'b0;
    else if (restart_w) de_o <= 1'b0;
    else                de_o <= in_range(ln_w, win_start.hi, win_stop.hi) &&
                                in_range(px_w, win_start.lo, win_stop.lo);
  end

endmodule

// File: rtl/vtg_timing_gen_chk.sv
module vtg_timing_gen_chk
  import vtg_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input coord_t        px,
  input coord_t        ln,
  input coord_t        len,
  input coord_t        half,
  input logic          ev_top,
  input logic          ev_bot,
  input logic [1:0]    status
);

  // R1
  px_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0) |-> (px < len));

  // R1
  ln_in_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_of(half) != '0) |-> (ln >= coord_t'(1) && ln <= lines_of(half)));

  // R2
  restart_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (px == '0 && ln == coord_t'(1)));

  // R7
  top_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_top |=> status[1]);

  // R11
  bot_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bot |=> status[0]);

  // R8
  clear_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(VTG_A_STAT_CLR) && bus_wdata[1] && !ev_top) |=> !status[1]);

endmodule

bind vtg_timing_gen vtg_timing_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart_w),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .px(px_w), .ln(ln_w), .len(len_a), .half(half_a),
  .ev_top(ev_top_w), .ev_bot(ev_bot_w), .status(status_w)
);

// File: tb/vtg_timing_gen_bench.sv
module vtg_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  hs, vs;
  logic        de, irq;

  int total = 0;
  int bad   = 0;
  int tick  = 0;
  int t0    = 0;
  bit done  = 0;

  int L, H, N;
  bit odd;
  int hst[4], hsp[4];
  int rln[2][4], rlo[2][4], fln[2][4], flo[2][4];
  int wsl[2], wsp[2], wel[2], wep[2];

  vtg_timing_gen u_vtg_timing_gen (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 12'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic restart();
    wr('h10, 1);
    t0 = tick;
  endtask

  task automatic wait_k(input int kk);
    while ((tick - t0) < kk) @(negedge clk);
  endtask

  function automatic int span(input int p, input int s, input int e);
    if (s <= e) return int'(p >= s && p <= e);
    return int'(p >= s || p <= e);
  endfunction

  task automatic program_all();
    wr('h08, L);
    wr('h0C, H);
    wr('h40, (wsl[0] << 16) | wsp[0]);
    wr('h44, (wel[0] << 16) | wep[0]);
    wr('h48, (wsl[1] << 16) | wsp[1]);
    wr('h4C, (wel[1] << 16) | wep[1]);
    for (int i = 0; i < 4; i++) begin
      wr('hC0 + 32*i + 'h0,  (hsp[i] << 16) | hst[i]);
      wr('hC0 + 32*i + 'h4,  (fln[0][i] << 16) | rln[0][i]);
      wr('hC0 + 32*i + 'h8,  (fln[1][i] << 16) | rln[1][i]);
      wr('hC0 + 32*i + 'hC,  (flo[0][i] << 16) | rlo[0][i]);
      wr('hC0 + 32*i + 'h10, (flo[1][i] << 16) | rlo[1][i]);
    end
    N = H / 2;
    odd = bit'(H % 2);
  endtask

  // call right after restart(); sample n reflects raster position n-1
  task automatic sweep(input int nsamp);
    bit vm[4];
    int k, px, ln, fld, ex;
    for (int i = 0; i < 4; i++) vm[i] = 0;
    for (int n = 1; n <= nsamp; n++) begin
      wait_k(n);
      k   = n - 1;
      px  = k % L;
      ln  = (k / L) % N + 1;
      fld = odd ? ((k / (L * N)) % 2) : 0;
      for (int i = 0; i < 4; i++) begin
        if (ln == rln[fld][i] && px == rlo[fld][i])      vm[i] = 1;
        else if (ln == fln[fld][i] && px == flo[fld][i]) vm[i] = 0;
        chk($sformatf("R1 R3 R6 hsync lane%0d k=%0d", i, k), int'(hs[i]), span(px, hst[i], hsp[i]));
        chk($sformatf("R4 R11 vsync lane%0d k=%0d", i, k), int'(vs[i]), int'(vm[i]));
      end
      ex = int'(ln >= wsl[fld] && ln <= wel[fld] && px >= wsp[fld] && px <= wep[fld]);
      chk($sformatf("R5 R11 de k=%0d", k), int'(de), ex);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 hsync", int'(hs), 0);
    chk("R12 vsync", int'(vs), 0);
    chk("R12 de", int'(de), 0);
    chk("R12 irq", int'(irq), 0);
    rd('h8C, d); chk("R12 mask", d, 0);
    rd('h08, d); chk("R12 line length", d, 16);
    rd('h0C, d); chk("R12 half lines", d, 16);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R12 irq masked after reset", int'(irq), 0);

    // configuration A: 16 x 8 progressive
    L = 16; H = 16;
    hst = '{5, 0, 7, 15}; hsp = '{7, 0, 2, 3};
    rln[0] = '{1, 1, 8, 3}; rlo[0] = '{5, 0, 7, 15};
    fln[0] = '{2, 2, 1, 4}; flo[0] = '{5, 0, 7, 2};
    for (int i = 0; i < 4; i++) begin
      rln[1][i] = 5; rlo[1][i] = 1; fln[1][i] = 6; flo[1][i] = 1;
    end
    wsl = '{3, 1}; wsp = '{4, 0}; wel = '{6, 8}; wep = '{13, 15};
    program_all();
    restart();
    sweep(256);

    // interrupt unit
    restart();
    wait_k(3);
    rd('h78, d); chk("R7 top status after restart", d, 2);
    wr('h7C, 1);
    rd('h78, d); chk("R8 clear of other bit leaves top", d, 2);
    wr('h7C, 2);
    rd('h78, d); chk("R8 clear top", d, 0);
    chk("R9 irq with mask zero", int'(irq), 0);
    wr('h8C, 2);
    rd('h8C, d); chk("R9 mask set", d, 2);
    chk("R9 irq no status", int'(irq), 0);
    wait_k(128);
    rd('h78, d); chk("R7 status not early", d, 0);
    chk("R9 irq not early", int'(irq), 0);
    wait_k(129);
    rd('h78, d); chk("R1 R7 status at next frame", d, 2);
    chk("R9 irq raised", int'(irq), 1);
    wr('h88, 1);
    rd('h8C, d); chk("R9 mask clear other bit", d, 2);
    chk("R9 irq still high", int'(irq), 1);
    wr('h88, 2);
    rd('h88, d); chk("R9 mask cleared", d, 0);
    chk("R9 irq masked off", int'(irq), 0);
    rd('h78, d); chk("R9 status kept while masked", d, 2);
    wr('h8C, 1);
    chk("R9 irq bottom mask only", int'(irq), 0);
    wr('h8C, 2);
    rd('h8C, d); chk("R9 mask both", d, 3);
    chk("R9 irq both", int'(irq), 1);
    wr('h7C, 3);
    rd('h78, d); chk("R8 clear both", d, 0);
    wait_k(256);
    wr('h7C, 2);
    rd('h78, d); chk("R8 event wins over clear", d, 2);

    // R10 deferred hsync write
    restart();
    wait_k(20);
    wr('hC0, (10 << 16) | 9);
    for (int n = 22; n <= 260; n++) begin
      int p, ex;
      wait_k(n);
      p  = n - 1;
      ex = (p < 128) ? span(p % 16, 5, 7) : span(p % 16, 9, 10);
      chk($sformatf("R10 hsync lane0 k=%0d", p), int'(hs[0]), ex);
    end

    // configuration B: 10 pixels, odd half-line count, alternating fields
    L = 10; H = 9;
    hst = '{2, 8, 0, 9}; hsp = '{4, 1, 9, 9};
    for (int i = 0; i < 4; i++) begin
      rln[0][i] = 1; rlo[0][i] = i;     fln[0][i] = 2; flo[0][i] = i + 1;
      rln[1][i] = 3; rlo[1][i] = 2;     fln[1][i] = 4; flo[1][i] = 8;
    end
    rln[1][2] = 4; rlo[1][2] = 0; fln[1][2] = 1; flo[1][2] = 3;
    wsl = '{1, 3}; wsp = '{0, 5}; wel = '{2, 4}; wep = '{9, 6};
    program_all();
    restart();
    sweep(170);

    restart();
    wait_k(3);
    wr('h7C, 3);
    rd('h78, d); chk("R11 status cleared", d, 0);
    wait_k(40);
    rd('h78, d); chk("R11 no bottom event yet", d, 0);
    wait_k(41);
    rd('h78, d); chk("R11 bottom event", d, 1);
    wait_k(81);
    rd('h78, d); chk("R11 top after bottom", d, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule